// File: doc/BRIEF.md
# Memory Write Guard with Two Protection Windows

This block sits beside a memory controller and checks every bus access against a fixed address map and two software-programmable write-protection windows. For each request it reports, in the same cycle, whether the memory write strobe must be suppressed. One cycle later it raises a single-cycle violation pulse with a cause code. The address map is set by parameters and has three implemented regions: a boot PROM, RAM and an I/O area. Any address outside them is illegal, whether the access is a read or a write, data or instruction.

Each protection window has a low bound, a high bound and an enable bit. A window applies only to data-qualified writes that land in RAM. Reads and instruction-qualified accesses pass through it untouched. Writes into the boot PROM are refused unless a configuration bit explicitly allows them. The window bounds and the control bits are loaded through a small register write port. After reset both windows are off, so all of RAM is writable.

Top module: `mag_write_guard`

## Requirements
- R1: An access (read or write, data or instruction) to an address outside the PROM, RAM and I/O regions produces viol=1 with viol_cause=1 on the cycle after the request, and a write there is masked (wr_mask=1).
- R2: A data write (acc_is_data=1) to a RAM address with lo ≤ addr ≤ hi of an enabled window has wr_mask=1 in the request cycle and produces viol=1 with viol_cause=3 on the next cycle. Both bounds are inclusive, and addresses one below lo or one above hi are not affected.
- R3: A read inside an enabled window is never masked and raises no violation.
- R4: An instruction-qualified write (acc_is_data=0) inside an enabled window is neither masked nor reported.
- R5: The two windows act independently. A window whose enable bit is 0 has no effect, whatever its bounds.
- R6: A write to the PROM region is masked and reported with viol_cause=2 unless control bit 2 is set. When that bit is set, the write proceeds with no violation. PROM reads are always allowed.
- R7: viol is high only on the cycle after a flagged request and drops on the following cycle unless another flagged request arrives. viol_cause is 0 whenever viol is 0.
- R8: After reset, viol=0 and viol_cause=0, both windows are disabled and PROM writes are refused.
- R9: The config port decodes cfg_sel as follows: 0 = window 0 low, 1 = window 0 high, 2 = window 1 low, 3 = window 1 high, 4 = control. In the control word, bit 0 enables window 0, bit 1 enables window 1 and bit 2 allows PROM writes. A write takes effect from the next cycle, and selector values 5 to 7 change nothing.
- R10: Window hits count only for addresses inside RAM. Writes to PROM (when allowed) and to I/O are unaffected by window bounds that cover them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access request valid this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_is_data | input | 1 | 1 = data access, 0 = instruction-space access |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 3 | Configuration register selector |
| cfg_wdata | input | ADDR_W | Configuration write data |
| wr_mask | output | 1 | Suppress the memory write strobe for the current request |
| viol | output | 1 | Registered violation pulse |
| viol_cause | output | 2 | Cause of the violation: 0 none, 1 unmapped, 2 PROM, 3 window |

## Verification
The bench builds the guard with a 16-bit address and a compact map: PROM at 0x0000–0x0FFF, RAM at 0x2000–0x5FFF and I/O at 0x8000–0x80FF. This places unmapped gaps on both sides of RAM and above I/O, so illegal-address detection can be tested right next to region edges. The narrow address also lets one window be widened to the full 0x0000–0xFFFF range, which exposes any leak of window hits into the PROM or I/O areas. Windows of one word and windows a few hundred words wide exercise the inclusive bounds at both ends.

// File: rtl/mag_pkg.sv
package mag_pkg;

    localparam int NSEG = 2;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_UNMAP  = 2'd1,
        CAUSE_PROM   = 2'd2,
        CAUSE_WINDOW = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_PROM = 2'd1,
        RGN_RAM  = 2'd2,
        RGN_IO   = 2'd3
    } region_e;

    localparam logic [2:0] SEL_CTRL = 3'd4;
    localparam int CTRL_PROM_BIT = NSEG;

endpackage

// File: rtl/mag_region_decode.sv
module mag_region_decode
    import mag_pkg::*;
#(
    parameter int               ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] PROM_LO = '0,
    parameter logic [ADDR_W-1:0] PROM_HI = '0,
    parameter logic [ADDR_W-1:0] RAM_LO  = '0,
    parameter logic [ADDR_W-1:0] RAM_HI  = '0,
    parameter logic [ADDR_W-1:0] IO_LO   = '0,
    parameter logic [ADDR_W-1:0] IO_HI   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    localparam logic [ADDR_W-1:0] PROM_SPAN = PROM_HI - PROM_LO;
    localparam logic [ADDR_W-1:0] RAM_SPAN  = RAM_HI - RAM_LO;
    localparam logic [ADDR_W-1:0] IO_SPAN   = IO_HI - IO_LO;

    logic [ADDR_W-1:0] prom_off;
    logic [ADDR_W-1:0] ram_off;
    logic [ADDR_W-1:0] io_off;
    logic              in_prom;
    logic              in_ram;
    logic              in_io;

    // One subtract-and-compare per region covers both bounds (unsigned wrap).
    always_comb begin
        prom_off = addr - PROM_LO;
        ram_off  = addr - RAM_LO;
        io_off   = addr - IO_LO;
        in_prom  = (prom_off <= PROM_SPAN);
        in_ram   = (ram_off <= RAM_SPAN);
        in_io    = (io_off <= IO_SPAN);
        if (in_prom)     region = RGN_PROM;
        else if (in_ram) region = RGN_RAM;
        else if (in_io)  region = RGN_IO;
        else             region = RGN_NONE;
    end

endmodule

// File: rtl/mag_seg_match.sv
module mag_seg_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic              en,
    output logic              hit
);

    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo = (addr >= lo);
        below_hi = (addr <= hi);
        hit      = en && above_lo && below_hi;
    end

endmodule

// File: rtl/mag_cfg_regs.sv
module mag_cfg_regs
    import mag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [2:0]                   cfg_sel,
    input  logic [ADDR_W-1:0]            cfg_wdata,
    output logic [NSEG-1:0][ADDR_W-1:0]  seg_lo,
    output logic [NSEG-1:0][ADDR_W-1:0]  seg_hi,
    output logic [NSEG-1:0]              seg_en,
    output logic                         prom_wr_en
);

    typedef struct packed {
        logic [NSEG-1:0][ADDR_W-1:0] lo;
        logic [NSEG-1:0][ADDR_W-1:0] hi;
        logic [NSEG-1:0]             en;
        logic                        prom_en;
    } cfg_t;

    cfg_t cfg_d;
    cfg_t cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            for (int i = 0; i < NSEG; i++) begin
                if (cfg_sel == 3'(2 * i))     cfg_d.lo[i] = cfg_wdata;
                if (cfg_sel == 3'(2 * i + 1)) cfg_d.hi[i] = cfg_wdata;
            end
            if (cfg_sel == SEL_CTRL) begin
                cfg_d.en      = cfg_wdata[NSEG-1:0];
                cfg_d.prom_en = cfg_wdata[CTRL_PROM_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign seg_lo     = cfg_q.lo;
    assign seg_hi     = cfg_q.hi;
    assign seg_en     = cfg_q.en;
    assign prom_wr_en = cfg_q.prom_en;

    // R8: the cycle after reset leaves every window disabled and PROM locked
    p_reset_locked_r8: assert property (@(posedge clk)
        !rst_n |=> (seg_en == '0) && !prom_wr_en);

    // R9: a selector above the control register never changes the enables
    p_bad_sel_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (cfg_sel > SEL_CTRL) |=> $stable(seg_en) && $stable(prom_wr_en));

endmodule

// File: rtl/mag_write_guard.sv
module mag_write_guard
    import mag_pkg::*;
#(
    parameter int               ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] PROM_LO = ADDR_W'(32'h0000_0000),
    parameter logic [ADDR_W-1:0] PROM_HI = ADDR_W'(32'h00FF_FFFF),
    parameter logic [ADDR_W-1:0] RAM_LO  = ADDR_W'(32'h0200_0000),
    parameter logic [ADDR_W-1:0] RAM_HI  = ADDR_W'(32'h03FF_FFFF),
    parameter logic [ADDR_W-1:0] IO_LO   = ADDR_W'(32'h1000_0000),
    parameter logic [ADDR_W-1:0] IO_HI   = ADDR_W'(32'h1000_FFFF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_is_data,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              wr_mask,
    output logic              viol,
    output logic [1:0]        viol_cause
);

    typedef struct packed {
        logic   viol;
        cause_e cause;
    } flag_t;

    logic [NSEG-1:0][ADDR_W-1:0] seg_lo;
    logic [NSEG-1:0][ADDR_W-1:0] seg_hi;
    logic [NSEG-1:0]             seg_en;
    logic                        prom_wr_en;
    logic [NSEG-1:0]             seg_hit;
    region_e                     region;
    cause_e                      cause_now;
    flag_t                       flag_d;
    flag_t                       flag_q;

    mag_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .seg_lo     (seg_lo),
        .seg_hi     (seg_hi),
        .seg_en     (seg_en),
        .prom_wr_en (prom_wr_en)
    );

    mag_region_decode #(
        .ADDR_W  (ADDR_W),
        .PROM_LO (PROM_LO),
        .PROM_HI (PROM_HI),
        .RAM_LO  (RAM_LO),
        .RAM_HI  (RAM_HI),
        .IO_LO   (IO_LO),
        .IO_HI   (IO_HI)
    ) u_decode (
        .addr   (acc_addr),
        .region (region)
    );

    for (genvar g = 0; g < NSEG; g++) begin : g_win
        mag_seg_match #(.ADDR_W(ADDR_W)) u_match (
            .addr (acc_addr),
            .lo   (seg_lo[g]),
            .hi   (seg_hi[g]),
            .en   (seg_en[g]),
            .hit  (seg_hit[g])
        );
    end

    // Classification: unmapped first, then PROM lock, then data windows in RAM.
    always_comb begin
        cause_now = CAUSE_NONE;
        if (region == RGN_NONE)
            cause_now = CAUSE_UNMAP;
        else if (acc_write && (region == RGN_PROM) && !prom_wr_en)
            cause_now = CAUSE_PROM;
        else if (acc_write && acc_is_data && (region == RGN_RAM) && (|seg_hit))
            cause_now = CAUSE_WINDOW;

        wr_mask      = acc_req && acc_write && (cause_now != CAUSE_NONE);
        flag_d.viol  = acc_req && (cause_now != CAUSE_NONE);
        flag_d.cause = flag_d.viol ? cause_now : CAUSE_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '{viol: 1'b0, cause: CAUSE_NONE};
        else        flag_q <= flag_d;
    end

    assign viol       = flag_q.viol;
    assign viol_cause = flag_q.cause;

    // R1: unmapped accesses are reported one cycle later as unmapped
    p_unmap_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && (region == RGN_NONE) |=> viol && (viol_cause == CAUSE_UNMAP));

    // R2: every suppressed write is also reported
    p_mask_reported_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> viol);

    // R3: reads are never masked
    p_read_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_write |-> !wr_mask);

    // R4: instruction-space traffic into RAM passes the windows
    p_instr_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_is_data && (region == RGN_RAM) |-> !wr_mask);

    // R6: locked PROM rejects writes
    p_prom_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_write && (region == RGN_PROM) && !prom_wr_en |-> wr_mask);

    // R7: a pulse always follows a request; no cause without a pulse
    p_pulse_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(acc_req));
    p_cause_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !viol |-> (viol_cause == CAUSE_NONE));

    // R10: windows never touch I/O
    p_io_untouched_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && (region == RGN_IO) |-> !wr_mask);

endmodule

// File: tb/tb_mag_write_guard.sv
`timescale 1ns/1ps
module tb_mag_write_guard;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_req = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_write = 1'b0;
    logic          acc_is_data = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          wr_mask;
    logic          viol;
    logic [1:0]    viol_cause;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    mag_write_guard #(
        .ADDR_W  (AW),
        .PROM_LO (16'h0000), .PROM_HI (16'h0FFF),
        .RAM_LO  (16'h2000), .RAM_HI  (16'h5FFF),
        .IO_LO   (16'h8000), .IO_HI   (16'h80FF)
    ) dut (
        .clk, .rst_n, .acc_req, .acc_addr, .acc_write, .acc_is_data,
        .cfg_we, .cfg_sel, .cfg_wdata, .wr_mask, .viol, .viol_cause
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [AW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One access: mask in the request cycle, pulse on the next, quiet after.
    task automatic access(input logic [AW-1:0] a, input logic wr, input logic dat,
                          input logic exp_mask, input logic [1:0] exp_cause,
                          input string tag);
        @(negedge clk);
        acc_req = 1'b1; acc_addr = a; acc_write = wr; acc_is_data = dat;
        #1;
        chk(wr_mask == exp_mask, {tag, " mask"}, wr_mask, exp_mask);
        @(posedge clk); #1;
        chk(viol == (exp_cause != 2'd0), {tag, " viol"}, viol, exp_cause != 2'd0);
        chk(viol_cause == exp_cause, {tag, " cause"}, viol_cause, exp_cause);
        @(negedge clk);
        acc_req = 1'b0;
        @(posedge clk); #1;
        chk(viol == 1'b0 && viol_cause == 2'd0, {tag, " R7 pulse drop"}, viol, 0);
    endtask

    task automatic t_reset;
        chk(viol == 1'b0, "R8 reset viol", viol, 0);
        chk(viol_cause == 2'd0, "R8 reset cause", viol_cause, 0);
        access(16'h3000, 1, 1, 0, 2'd0, "R8 RAM writable after reset");
        access(16'h0100, 1, 1, 1, 2'd2, "R8 PROM locked after reset");
    endtask

    task automatic t_unmapped;
        access(16'h1000, 0, 1, 0, 2'd1, "R1 data read gap above PROM");
        access(16'h6000, 0, 0, 0, 2'd1, "R1 instr read gap above RAM");
        access(16'h1FFF, 1, 1, 1, 2'd1, "R1 write just below RAM");
        access(16'h8100, 1, 0, 1, 2'd1, "R1 instr write above IO");
        access(16'hF000, 1, 1, 1, 2'd1, "R1 data write top gap");
    endtask

    task automatic t_prom;
        access(16'h0FFF, 0, 1, 0, 2'd0, "R6 PROM read");
        cfg_write(3'd4, 16'h0004);
        access(16'h0100, 1, 1, 0, 2'd0, "R6 PROM write allowed");
        access(16'h8010, 1, 1, 0, 2'd0, "R6 IO write");
    endtask

    task automatic t_window0;
        cfg_write(3'd0, 16'h3000);
        cfg_write(3'd1, 16'h30FF);
        access(16'h3000, 1, 1, 0, 2'd0, "R5 disabled window inert");
        cfg_write(3'd4, 16'h0005);
        access(16'h3000, 1, 1, 1, 2'd3, "R2 low bound");
        access(16'h30FF, 1, 1, 1, 2'd3, "R2 high bound");
        access(16'h2FFF, 1, 1, 0, 2'd0, "R2 below low");
        access(16'h3100, 1, 1, 0, 2'd0, "R2 above high");
        access(16'h3050, 0, 1, 0, 2'd0, "R3 read inside window");
        access(16'h3050, 1, 0, 0, 2'd0, "R4 instr write inside window");
    endtask

    task automatic t_two_windows;
        cfg_write(3'd2, 16'h4000);
        cfg_write(3'd3, 16'h4000);
        cfg_write(3'd4, 16'h0007);
        access(16'h4000, 1, 1, 1, 2'd3, "R5 window1 single word");
        access(16'h4001, 1, 1, 0, 2'd0, "R5 window1 next word");
        access(16'h3080, 1, 1, 1, 2'd3, "R5 window0 still active");
        cfg_write(3'd4, 16'h0006);
        access(16'h3080, 1, 1, 0, 2'd0, "R5 window0 disabled");
        access(16'h4000, 1, 1, 1, 2'd3, "R5 window1 independent");
    endtask

    task automatic t_ram_only;
        cfg_write(3'd2, 16'h0000);
        cfg_write(3'd3, 16'hFFFF);
        access(16'h8010, 1, 1, 0, 2'd0, "R10 IO under full window");
        access(16'h0200, 1, 1, 0, 2'd0, "R10 PROM under full window");
        access(16'h5FFF, 1, 1, 1, 2'd3, "R10 RAM top under full window");
    endtask

    task automatic t_cfg_decode;
        cfg_write(3'd4, 16'h0004);
        access(16'h2000, 1, 1, 0, 2'd0, "R9 windows off via control");
        cfg_write(3'd5, 16'hFFFF);
        access(16'h2000, 1, 1, 0, 2'd0, "R9 sel5 ignored");
        cfg_write(3'd7, 16'hFFFF);
        access(16'h2000, 1, 1, 0, 2'd0, "R9 sel7 ignored");
        access(16'h0100, 1, 1, 0, 2'd0, "R9 PROM bit kept");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset;
        t_unmapped;
        t_prom;
        t_window0;
        t_two_windows;
        t_ram_only;
        t_cfg_decode;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule